// File: doc/BRIEF.md
# Flash Operating-Mode and Reset Controller

This block is the mode state machine at the top of a flash memory command interface. A command decoder upstream turns bus write sequences into single-cycle strobes. The embedded program and erase engines report completion or failure. From these inputs the controller tracks which operating mode the device is in: array read, identifier (autoselect) read, sector protection operation, configuration register read, programming, erasing, erase suspended, or a failed operation. It exports that mode as a 4-bit code.

Two kinds of reset are handled. A software reset command leaves the identifier, protection, configuration-read and failure modes. It goes to erase-suspend read when an erase is parked, and to array read otherwise. The active-low hardware reset pin only takes effect once it has been held low for a minimum number of clock cycles. It then aborts any embedded operation, pulses a configuration register reset, parks the outputs in high impedance, and holds the device in a reset state until the pin rises. A recovery interval follows before commands are accepted again. While the pin is low, every command strobe is dropped, even during a pulse too short to qualify.

The ready output and the output-driver enable are both gated by the active-low chip enable.

Top module: `flash_mode_ctrl`

## Requirements
- R1: When `reset_pin_n` has been sampled low on MIN_LOW consecutive rising clock edges, the outputs after that edge show: `mode` = 8 (reset hold), `cfg_rst` = 1 for exactly one cycle, `op_abort` = 1 for one cycle if the prior mode was 4, 5 or 6, and the erase-suspended flag is cleared.
- R2: A low pulse on `reset_pin_n` that lasts fewer than MIN_LOW sampled edges leaves `mode` unchanged, and `cfg_rst` and `op_abort` stay 0.
- R3: On any edge where `reset_pin_n` is low, all command strobes (`cmd_*`) are ignored. `op_done` and `op_fail` are still honoured in modes 4 and 5 until the pulse qualifies.
- R4: In mode 8, `out_en` and `rdy` are 0 whatever `ce_n` is.
- R5: The first edge in mode 8 with `reset_pin_n` high moves the block to mode 9 (recovery). `mode` stays 9 for REC_CYC cycles, with `rdy` = 0 and every input other than `reset_pin_n` ignored, and then becomes 0.
- R6: `cmd_swreset` in mode 1 (identifier), 2 (protection) or 3 (configuration read) returns the block to mode 0. Every other command in those modes is ignored.
- R7: `op_fail` in mode 4 or 5 enters mode 7 (failed). Mode 7 is left only by `cmd_swreset` or a qualified hardware reset.
- R8: `cmd_swreset` in modes 1, 2, 3, 6 or 7 leads to mode 6 when an erase is suspended, and to mode 0 when none is.
- R9: `cmd_suspend` in mode 5 enters mode 6. In mode 6, `cmd_resume` returns to mode 5, and `cmd_prog` enters mode 4. After that program, `op_done` returns to mode 6. `cmd_autosel` and `cmd_cfgrd` from mode 6 enter modes 1 and 3. `op_done` in mode 5 goes to mode 0.
- R10: `op_fail` beats `op_done`, and in modes 4 and 5 an operation result beats any command. Among commands, only the highest asserted strobe is considered, in this order: swreset, suspend, resume, prog, erase, lock, cfgrd, autosel. If that strobe does nothing in the current mode, nothing happens.
- R11: `rdy` = !`ce_n` in every mode except 8 and 9. `out_en` = !`ce_n` in every mode except 8.
- R12: After `rst_n` the block is in mode 0 with `cfg_rst` = 0 and `op_abort` = 0. From mode 0, the commands prog, erase, lock, cfgrd and autosel enter modes 4, 5, 2, 3 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| reset_pin_n | input | 1 | Hardware reset pin, active low, already synchronised |
| ce_n | input | 1 | Chip enable, active low |
| cmd_swreset | input | 1 | Software reset command strobe |
| cmd_autosel | input | 1 | Enter identifier read strobe |
| cmd_lock | input | 1 | Sector protection operation strobe |
| cmd_cfgrd | input | 1 | Configuration register read strobe |
| cmd_prog | input | 1 | Program command strobe |
| cmd_erase | input | 1 | Erase command strobe |
| cmd_suspend | input | 1 | Erase suspend strobe |
| cmd_resume | input | 1 | Erase resume strobe |
| op_done | input | 1 | Embedded operation completed |
| op_fail | input | 1 | Embedded operation failed |
| rdy | output | 1 | Ready indication, gated by chip enable |
| out_en | output | 1 | Output driver enable, 0 means tristate |
| cfg_rst | output | 1 | One-cycle configuration register reset |
| op_abort | output | 1 | One-cycle abort to the embedded engine |
| mode | output | 4 | Current mode code |

## Verification
The hardest state to reach is a program that fails while an erase is suspended. Getting there takes an erase, a suspend and a program in that order, and then the software reset must land in erase-suspend read instead of array read. The directed stimulus walks that chain. A second directed pass sends a qualifying hardware pulse from the suspended state, which checks that the abort fires and that the suspended flag is gone. Reset pulses one cycle shorter than the minimum, pulses re-asserted during recovery, and colliding strobes are covered by a random phase. That phase draws pin-low bursts with lengths around MIN_LOW and compares every output against the reference model on every cycle.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;

    typedef enum logic [3:0] {
        MD_ARRAY = 4'd0,
        MD_AUTO  = 4'd1,
        MD_LOCK  = 4'd2,
        MD_CFG   = 4'd3,
        MD_PROG  = 4'd4,
        MD_ERASE = 4'd5,
        MD_SUSP  = 4'd6,
        MD_FAIL  = 4'd7,
        MD_HOLD  = 4'd8,
        MD_RECOV = 4'd9
    } mode_t;

    // command strobe positions, lowest index wins
    localparam int NCMD     = 8;
    localparam int G_SWRST  = 0;
    localparam int G_SUSP   = 1;
    localparam int G_RESUME = 2;
    localparam int G_PROG   = 3;
    localparam int G_ERASE  = 4;
    localparam int G_LOCK   = 5;
    localparam int G_CFG    = 6;
    localparam int G_AUTO   = 7;

    typedef struct packed {
        mode_t mode;
        logic  susp;
        logic  cfg_rst;
        logic  abort;
    } ctrl_t;

endpackage

// File: rtl/flash_cmd_arb.sv
module flash_cmd_arb #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N-1:0] seen;

    assign seen[0]  = req[0];
    assign grant[0] = req[0];

    for (genvar i = 1; i < N; i++) begin : g_pri
        assign grant[i] = req[i] & ~seen[i-1];
        assign seen[i]  = seen[i-1] | req[i];
    end
endmodule

// File: rtl/flash_rst_qual.sv
module flash_rst_qual #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic qual
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);
    localparam logic [CW-1:0] SAT  = CW'(MIN_LOW);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (pin_n)
            cnt_d = '0;
        else if (cnt_q != SAT)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign qual = !pin_n && (cnt_q == LAST);

    // R1: a held-low pin qualifies once, not on every cycle
    a_r1_single_qual: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> !qual);
    // R2: a rising pin clears any partial count
    a_r2_pin_high_no_qual: assert property (@(posedge clk) disable iff (!rst_n)
        pin_n |=> (pin_n || !qual || MIN_LOW == 1));
endmodule

// File: rtl/flash_rec_timer.sv
module flash_rec_timer #(
    parameter int REC_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic expired
);
    localparam int RW = $clog2(REC_CYC + 1);
    localparam logic [RW-1:0] START = RW'(REC_CYC - 1);

    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = START;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R5: a loaded recovery interval is not already over
    a_r5_load_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
        (load && REC_CYC > 1) |=> !expired);
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
    import flash_mode_pkg::*;
#(
    parameter int MIN_LOW = 4,
    parameter int REC_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reset_pin_n,
    input  logic       ce_n,
    input  logic       cmd_swreset,
    input  logic       cmd_autosel,
    input  logic       cmd_lock,
    input  logic       cmd_cfgrd,
    input  logic       cmd_prog,
    input  logic       cmd_erase,
    input  logic       cmd_suspend,
    input  logic       cmd_resume,
    input  logic       op_done,
    input  logic       op_fail,
    output logic       rdy,
    output logic       out_en,
    output logic       cfg_rst,
    output logic       op_abort,
    output logic [3:0] mode
);
    ctrl_t cur_q, nxt_d;
    logic [NCMD-1:0] req, grant;
    logic qual, rec_load, rec_dec, rec_expired, cmd_ok;
    mode_t back_mode;

    assign req = {cmd_autosel, cmd_cfgrd, cmd_lock, cmd_erase,
                  cmd_prog, cmd_resume, cmd_suspend, cmd_swreset};

    flash_cmd_arb #(.N(NCMD)) u_arb (
        .req   (req),
        .grant (grant)
    );

    flash_rst_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (reset_pin_n),
        .qual  (qual)
    );

    flash_rec_timer #(.REC_CYC(REC_CYC)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rec_load),
        .dec     (rec_dec),
        .expired (rec_expired)
    );

    assign cmd_ok    = reset_pin_n;
    assign back_mode = cur_q.susp ? MD_SUSP : MD_ARRAY;

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.cfg_rst = 1'b0;
        nxt_d.abort   = 1'b0;
        rec_load      = 1'b0;
        rec_dec       = 1'b0;
        if (qual) begin
            nxt_d.mode    = MD_HOLD;
            nxt_d.susp    = 1'b0;
            nxt_d.cfg_rst = 1'b1;
            nxt_d.abort   = (cur_q.mode == MD_PROG) || (cur_q.mode == MD_ERASE)
                         || (cur_q.mode == MD_SUSP);
        end else begin
            case (cur_q.mode)
                MD_HOLD: begin
                    if (reset_pin_n) begin
                        nxt_d.mode = MD_RECOV;
                        rec_load   = 1'b1;
                    end
                end
                MD_RECOV: begin
                    if (rec_expired) nxt_d.mode = MD_ARRAY;
                    else             rec_dec    = 1'b1;
                end
                MD_PROG: begin
                    if (op_fail)      nxt_d.mode = MD_FAIL;
                    else if (op_done) nxt_d.mode = back_mode;
                end
                MD_ERASE: begin
                    if (op_fail) begin
                        nxt_d.mode = MD_FAIL;
                        nxt_d.susp = 1'b0;
                    end else if (op_done) begin
                        nxt_d.mode = MD_ARRAY;
                        nxt_d.susp = 1'b0;
                    end else if (cmd_ok && grant[G_SUSP]) begin
                        nxt_d.mode = MD_SUSP;
                        nxt_d.susp = 1'b1;
                    end
                end
                MD_ARRAY: begin
                    if (cmd_ok) begin
                        if (grant[G_PROG])       nxt_d.mode = MD_PROG;
                        else if (grant[G_ERASE]) nxt_d.mode = MD_ERASE;
                        else if (grant[G_LOCK])  nxt_d.mode = MD_LOCK;
                        else if (grant[G_CFG])   nxt_d.mode = MD_CFG;
                        else if (grant[G_AUTO])  nxt_d.mode = MD_AUTO;
                    end
                end
                MD_AUTO, MD_LOCK, MD_CFG, MD_FAIL: begin
                    if (cmd_ok && grant[G_SWRST]) nxt_d.mode = back_mode;
                end
                MD_SUSP: begin
                    if (cmd_ok) begin
                        if (grant[G_SWRST]) begin
                            nxt_d.mode = back_mode;
                        end else if (grant[G_RESUME]) begin
                            nxt_d.mode = MD_ERASE;
                            nxt_d.susp = 1'b0;
                        end else if (grant[G_PROG]) begin
                            nxt_d.mode = MD_PROG;
                        end else if (grant[G_CFG]) begin
                            nxt_d.mode = MD_CFG;
                        end else if (grant[G_AUTO]) begin
                            nxt_d.mode = MD_AUTO;
                        end
                    end
                end
                default: nxt_d.mode = MD_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mode    <= MD_ARRAY;
            cur_q.susp    <= 1'b0;
            cur_q.cfg_rst <= 1'b0;
            cur_q.abort   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mode     = cur_q.mode;
    assign cfg_rst  = cur_q.cfg_rst;
    assign op_abort = cur_q.abort;
    assign rdy      = !ce_n && (cur_q.mode != MD_HOLD) && (cur_q.mode != MD_RECOV);
    assign out_en   = !ce_n && (cur_q.mode != MD_HOLD);

    // R1: a qualified pulse lands in reset hold with a config reset pulse
    a_r1_hold_after_qual: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> (mode == MD_HOLD) && cfg_rst);
    // R3: commands are dropped while the pin is low
    a_r3_cmds_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_pin_n && cur_q.mode == MD_ARRAY && !qual) |=> (mode == MD_ARRAY));
    // R7: the failed mode persists until a software reset
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode == MD_FAIL && !cmd_swreset && reset_pin_n) |=> (mode == MD_FAIL));
    // R8: erase-suspend read always carries the suspended flag
    a_r8_susp_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode == MD_SUSP) |-> cur_q.susp);
    // R9: a lone resume in suspend goes back to erasing
    a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode == MD_SUSP && reset_pin_n && cmd_resume && !cmd_swreset
         && !cmd_suspend) |=> (mode == MD_ERASE));
endmodule

// File: tb/flash_mode_ctrl_bench.sv
module flash_mode_ctrl_bench;
    localparam int MIN_LOW = 4;
    localparam int REC_CYC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_pin_n = 1'b1, ce_n = 1'b1;
    logic cmd_swreset = 0, cmd_autosel = 0, cmd_lock = 0, cmd_cfgrd = 0;
    logic cmd_prog = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0;
    logic op_done = 0, op_fail = 0;
    logic rdy, out_en, cfg_rst, op_abort;
    logic [3:0] mode;

    int total = 0, fails = 0;
    bit finished = 0;
    string cur_req = "R12";

    always #10 clk = ~clk;

    flash_mode_ctrl #(.MIN_LOW(MIN_LOW), .REC_CYC(REC_CYC)) u_flash_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .reset_pin_n(reset_pin_n), .ce_n(ce_n),
        .cmd_swreset(cmd_swreset), .cmd_autosel(cmd_autosel), .cmd_lock(cmd_lock),
        .cmd_cfgrd(cmd_cfgrd), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
        .op_done(op_done), .op_fail(op_fail),
        .rdy(rdy), .out_en(out_en), .cfg_rst(cfg_rst), .op_abort(op_abort),
        .mode(mode)
    );

    function automatic void chk(string what, string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endfunction

    // reference model
    int m_mode = 0, m_low = 0, m_rec = 0;
    bit m_susp = 0, m_cfg = 0, m_abort = 0;

    always @(posedge clk or negedge rst_n) begin
        int nm, sel;
        bit ns, q;
        if (!rst_n) begin
            m_mode = 0; m_low = 0; m_rec = 0; m_susp = 0; m_cfg = 0; m_abort = 0;
        end else begin
            nm = m_mode; ns = m_susp;
            q = !reset_pin_n && (m_low == MIN_LOW - 1);
            if (reset_pin_n) m_low = 0;
            else if (m_low < MIN_LOW) m_low++;
            sel = 8;
            if (cmd_autosel) sel = 7;
            if (cmd_cfgrd)   sel = 6;
            if (cmd_lock)    sel = 5;
            if (cmd_erase)   sel = 4;
            if (cmd_prog)    sel = 3;
            if (cmd_resume)  sel = 2;
            if (cmd_suspend) sel = 1;
            if (cmd_swreset) sel = 0;
            if (!reset_pin_n) sel = 8;
            m_abort = 0;
            m_cfg = 0;
            if (q) begin
                m_abort = (m_mode >= 4 && m_mode <= 6);
                nm = 8; ns = 0; m_cfg = 1;
            end else if (m_mode == 8) begin
                if (reset_pin_n) begin nm = 9; m_rec = REC_CYC - 1; end
            end else if (m_mode == 9) begin
                if (m_rec == 0) nm = 0; else m_rec--;
            end else if (m_mode == 4) begin
                if (op_fail) nm = 7;
                else if (op_done) nm = m_susp ? 6 : 0;
            end else if (m_mode == 5) begin
                if (op_fail) begin nm = 7; ns = 0; end
                else if (op_done) begin nm = 0; ns = 0; end
                else if (sel == 1) begin nm = 6; ns = 1; end
            end else if (m_mode == 0) begin
                case (sel)
                    3: nm = 4; 4: nm = 5; 5: nm = 2; 6: nm = 3; 7: nm = 1;
                    default: ;
                endcase
            end else if (m_mode == 6) begin
                case (sel)
                    0: nm = 6;
                    2: begin nm = 5; ns = 0; end
                    3: nm = 4; 6: nm = 3; 7: nm = 1;
                    default: ;
                endcase
            end else begin
                if (sel == 0) nm = m_susp ? 6 : 0;
            end
            m_mode = nm; m_susp = ns;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("mode", cur_req, int'(mode), m_mode);
            chk("cfg_rst", cur_req, int'(cfg_rst), int'(m_cfg));
            chk("op_abort", cur_req, int'(op_abort), int'(m_abort));
            chk("rdy", cur_req, int'(rdy), int'(!ce_n && m_mode != 8 && m_mode != 9));
            chk("out_en", cur_req, int'(out_en), int'(!ce_n && m_mode != 8));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        cmd_swreset = 0; cmd_autosel = 0; cmd_lock = 0; cmd_cfgrd = 0;
        cmd_prog = 0; cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0;
        op_done = 0; op_fail = 0;
    endtask

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        int lowrun = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R12";
        chk("reset mode", "R12", int'(mode), 0);
        chk("reset cfg_rst", "R12", int'(cfg_rst), 0);
        chk("reset op_abort", "R12", int'(op_abort), 0);

        cur_req = "R11";
        ce_n = 0; #1;
        chk("rdy ce low", "R11", int'(rdy), 1);
        chk("out_en ce low", "R11", int'(out_en), 1);
        tick();

        cur_req = "R6";
        cmd_autosel = 1; tick(); clr();
        chk("autosel entry", "R12", int'(mode), 1);
        cmd_prog = 1; tick(); clr();
        chk("prog ignored in autoselect", "R6", int'(mode), 1);
        cmd_swreset = 1; tick(); clr();
        chk("swreset from autoselect", "R6", int'(mode), 0);
        cmd_lock = 1; tick(); clr();
        chk("lock entry", "R12", int'(mode), 2);
        cmd_swreset = 1; tick(); clr();
        chk("swreset from lock", "R6", int'(mode), 0);
        cmd_cfgrd = 1; tick(); clr();
        chk("cfg entry", "R12", int'(mode), 3);
        cmd_swreset = 1; tick(); clr();
        chk("swreset from cfg read", "R6", int'(mode), 0);

        cur_req = "R7";
        cmd_prog = 1; tick(); clr();
        op_fail = 1; tick(); clr();
        chk("program fail", "R7", int'(mode), 7);
        cmd_autosel = 1; tick(); clr();
        chk("fail sticky", "R7", int'(mode), 7);
        cmd_swreset = 1; tick(); clr();
        chk("swreset leaves fail", "R7", int'(mode), 0);

        cur_req = "R9";
        cmd_erase = 1; tick(); clr();
        cmd_suspend = 1; tick(); clr();
        chk("erase suspend", "R9", int'(mode), 6);
        cmd_prog = 1; tick(); clr();
        op_done = 1; tick(); clr();
        chk("program in suspend returns", "R9", int'(mode), 6);
        cur_req = "R8";
        cmd_autosel = 1; tick(); clr();
        cmd_swreset = 1; tick(); clr();
        chk("swreset to suspend read", "R8", int'(mode), 6);
        cmd_prog = 1; tick(); clr();
        op_fail = 1; tick(); clr();
        cmd_swreset = 1; tick(); clr();
        chk("swreset after suspended fail", "R8", int'(mode), 6);
        cur_req = "R9";
        cmd_resume = 1; tick(); clr();
        chk("resume", "R9", int'(mode), 5);
        op_done = 1; tick(); clr();
        chk("erase done", "R9", int'(mode), 0);

        cur_req = "R10";
        cmd_erase = 1; tick(); clr();
        cmd_suspend = 1; op_done = 1; tick(); clr();
        chk("done beats suspend", "R10", int'(mode), 0);
        cmd_prog = 1; cmd_erase = 1; cmd_swreset = 1; tick(); clr();
        chk("swreset masks prog", "R10", int'(mode), 0);
        cmd_prog = 1; cmd_erase = 1; tick(); clr();
        chk("prog beats erase", "R10", int'(mode), 4);
        op_done = 1; op_fail = 1; tick(); clr();
        chk("fail beats done", "R10", int'(mode), 7);
        cmd_swreset = 1; tick(); clr();

        cur_req = "R2";
        cmd_erase = 1; tick(); clr();
        reset_pin_n = 0; cmd_suspend = 1;
        repeat (MIN_LOW - 1) tick();
        reset_pin_n = 1; clr();
        chk("short pulse keeps mode", "R2", int'(mode), 5);
        chk("short pulse no cfg_rst", "R2", int'(cfg_rst), 0);
        chk("cmd ignored while pin low", "R3", int'(mode), 5);

        cur_req = "R1";
        cmd_suspend = 1; tick(); clr();
        reset_pin_n = 0;
        repeat (MIN_LOW) tick();
        chk("hold after pulse", "R1", int'(mode), 8);
        chk("cfg_rst pulse", "R1", int'(cfg_rst), 1);
        chk("abort from suspend", "R1", int'(op_abort), 1);
        chk("tristate in hold", "R4", int'(out_en), 0);
        chk("rdy low in hold", "R4", int'(rdy), 0);
        cmd_prog = 1; tick(); clr();
        chk("cfg_rst single", "R1", int'(cfg_rst), 0);
        chk("cmd in hold ignored", "R3", int'(mode), 8);
        cur_req = "R5";
        reset_pin_n = 1; cmd_autosel = 1; tick();
        for (int i = 0; i < REC_CYC; i++) begin
            chk("recovery mode", "R5", int'(mode), 9);
            chk("recovery rdy", "R5", int'(rdy), 0);
            tick();
        end
        clr();
        chk("recovery ends in array", "R5", int'(mode), 0);
        cmd_swreset = 1; tick(); clr();
        chk("suspend flag cleared by pin", "R8", int'(mode), 0);

        cur_req = "R10";
        for (int c = 0; c < 3000; c++) begin
            cmd_swreset = ($urandom_range(0, 7) == 0);
            cmd_autosel = ($urandom_range(0, 5) == 0);
            cmd_lock    = ($urandom_range(0, 7) == 0);
            cmd_cfgrd   = ($urandom_range(0, 6) == 0);
            cmd_prog    = ($urandom_range(0, 5) == 0);
            cmd_erase   = ($urandom_range(0, 5) == 0);
            cmd_suspend = ($urandom_range(0, 4) == 0);
            cmd_resume  = ($urandom_range(0, 4) == 0);
            op_done     = ($urandom_range(0, 4) == 0);
            op_fail     = ($urandom_range(0, 12) == 0);
            ce_n        = ($urandom_range(0, 3) == 0);
            if (lowrun > 0) begin
                reset_pin_n = 0; lowrun--;
            end else if ($urandom_range(0, 40) == 0) begin
                lowrun = $urandom_range(MIN_LOW - 2, MIN_LOW + 3);
                reset_pin_n = 0;
            end else begin
                reset_pin_n = 1;
            end
            tick();
        end
        clr();
        reset_pin_n = 1;
        repeat (REC_CYC + 2) tick();
        summary();
    end
endmodule